// File: doc/BRIEF.md
# Stereo Digital Volume and Peak Monitor

This block is the per-channel digital gain stage placed in front of a stereo audio DAC. Left and right signed 24-bit PCM samples arrive together on a valid/ready stream. Each sample is scaled by its channel's logarithmic attenuation and leaves on a second valid/ready stream one cycle later. The attenuation runs in steps of 0.375 dB. Either channel can be muted, and both channels leave reset muted so that configuration produces no audible output.

Alongside the gain path, each channel tracks the largest input magnitude seen since its last readout, and a read of that value clears it. Each channel also counts consecutive all-zero input samples and raises a flag pin once a long silent run has been seen. A small register port sets the volumes and mutes and returns the peak values.

On the input stream a sample pair is taken on any clock edge where `s_valid` and `s_ready` are both high. The output holds one pair. `s_ready` is high whenever that holding stage is empty or is being drained in the same cycle. When the downstream side holds `m_ready` low, the output pair and `m_valid` stay frozen and no new input is taken.

Top module: `stereo_vol_peak`

## Requirements
- R1: After reset, both mute bits are 1, both volume steps are 0, both peaks are 0, both zero flags are 0 and `m_valid` is 0.
- R2: With a channel unmuted and volume step n, the coefficient is c = round(32768·10^(-0.375·n/20)). The output sample is floor((x·c + 16384)/32768). Step 0 gives c = 32768, which is unity gain.
- R3: Register address 2 holds the mute bits: bit 0 is left and bit 1 is right, and 1 means muted. A sample taken while its channel is muted leaves as 0.
- R4: `s_ready` = !`m_valid` || `m_ready`. An accepted pair appears on `m_left`/`m_right` with `m_valid` high after the accepting edge. While `m_valid` is high and `m_ready` is low, the output pair stays unchanged.
- R5: A volume write changes only samples accepted after the write. A pair held at the output during a stall keeps the gain it was accepted with.
- R6: Each channel's peak is the largest |x| over samples accepted since the last clear, measured before attenuation. An input of −2^23 counts as 2^23−1.
- R7: A read of address 3 (left) or address 4 (right) returns the peak on `reg_rdata` after the read edge, and clears that peak to 0.
- R8: If a peak read and an accepted sample coincide, the peak afterwards equals that sample's magnitude.
- R9: A channel's zero flag rises on the edge that accepts the 1024th consecutive all-zero sample of that channel. It falls on the edge that accepts a non-zero sample.
- R10: Addresses 0 and 1 hold the left and right volume steps, read back on `reg_rdata`. Each channel's gain depends only on its own step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pair valid |
| s_ready | output | 1 | Block can take an input pair |
| s_left | input | 24 | Left input sample, signed |
| s_right | input | 24 | Right input sample, signed |
| m_valid | output | 1 | Output pair valid |
| m_ready | input | 1 | Downstream takes the output pair |
| m_left | output | 24 | Left output sample, signed |
| m_right | output | 24 | Right output sample, signed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 24 | Read data, registered |
| zero_l | output | 1 | Left silent-run flag |
| zero_r | output | 1 | Right silent-run flag |

## Verification
The assertions check several rules on every cycle. They check that the stalled output holds, that a sample taken while muted leaves as zero, and that a non-zero sample drops the zero flag at once. They also check that a peak read leaves the peak at zero, or at the coinciding sample's magnitude. Only the bench scenarios can show the exact attenuation values across steps, the saturation of the most negative input, and the exact 1024-sample threshold of the flag. The same holds for a volume write made during a stall, which must apply only to later samples.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int NCH = 2;

  // unsigned fixed-point gain with FRAC fraction bits, rounded to nearest
  function automatic int gain_code(int step, int frac);
    real g;
    g = 10.0 ** (-0.375 * real'(step) / 20.0);
    return $rtoi(g * real'(1 << frac) + 0.5);
  endfunction
endpackage

// File: rtl/vol_coef_rom.sv
module vol_coef_rom #(
  parameter int STEPS  = 256,
  parameter int COEF_W = 16,
  localparam int SEL_W = $clog2(STEPS)
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [COEF_W-1:0] coef
);
  localparam int FRAC = COEF_W - 1;

  logic [COEF_W-1:0] table_q [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_entry
    localparam int CODE = svp_pkg::gain_code(i, FRAC);
    assign table_q[i] = COEF_W'(CODE);
  end

  assign coef = table_q[sel];
endmodule

// File: rtl/chan_gain.sv
module chan_gain #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0]        coef,
  input  logic                     mute,
  output logic signed [DATA_W-1:0] result
);
  localparam int FRAC  = COEF_W - 1;
  localparam int PROD_W = DATA_W + COEF_W + 1;

  logic signed [COEF_W:0]   coef_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;

  always_comb begin
    coef_s  = $signed({1'b0, coef});
    prod    = PROD_W'(sample) * PROD_W'(coef_s);
    rounded = (prod + (PROD_W'(1) <<< (FRAC - 1))) >>> FRAC;
    result  = mute ? '0 : rounded[DATA_W-1:0];
  end
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic                     clr,
  output logic [DATA_W-1:0]        peak
);
  localparam logic [DATA_W-1:0] MAXMAG = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MINVAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] mag;

  always_comb begin
    if (sample == $signed(MINVAL)) mag = MAXMAG;
    else if (sample < 0)           mag = DATA_W'(-sample);
    else                           mag = DATA_W'(sample);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     peak <= '0;
    else if (clr)                   peak <= in_valid ? mag : '0;
    else if (in_valid && mag > peak) peak <= mag;
  end

  // R8
  clr_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && in_valid) |=> (peak == $past(mag)));
  // R7
  clr_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (peak == '0));
  // R6
  peak_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> (peak >= $past(mag)));
endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 1024,
  localparam int CNT_W   = $clog2(ZERO_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sample,
  output logic              flag
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (in_valid) begin
      if (sample != '0)       run_q <= '0;
      else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end
  end

  assign flag = (run_q == LIMIT);

  // R9
  nonzero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sample != '0) |=> !flag);
endmodule

// File: rtl/stereo_vol_peak.sv
module stereo_vol_peak #(
  parameter int DATA_W   = 24,
  parameter int COEF_W   = 16,
  parameter int STEPS    = 256,
  parameter int ZERO_RUN = 1024,
  parameter int ADDR_W   = 3,
  localparam int STEP_W  = $clog2(STEPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [DATA_W-1:0] s_left,
  input  logic signed [DATA_W-1:0] s_right,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic signed [DATA_W-1:0] m_left,
  output logic signed [DATA_W-1:0] m_right,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [STEP_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     zero_l,
  output logic                     zero_r
);
  import svp_pkg::*;

  localparam logic [ADDR_W-1:0] A_VOL0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MUTE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PK0  = ADDR_W'(3);

  logic [STEP_W-1:0]        vol_q  [NCH];
  logic [NCH-1:0]           mute_q;
  logic signed [DATA_W-1:0] in_ch  [NCH];
  logic signed [DATA_W-1:0] gain_ch[NCH];
  logic [DATA_W-1:0]        peak_ch[NCH];
  logic [NCH-1:0]           zflag;
  logic                     accept;

  assign in_ch[0] = s_left;
  assign in_ch[1] = s_right;
  assign s_ready  = !m_valid || m_ready;
  assign accept   = s_valid && s_ready;

  // control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) vol_q[c] <= '0;
      mute_q <= '1;
    end else if (reg_wr) begin
      for (int c = 0; c < NCH; c++)
        if (reg_addr == A_VOL0 + ADDR_W'(c)) vol_q[c] <= reg_wdata;
      if (reg_addr == A_MUTE) mute_q <= reg_wdata[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [COEF_W-1:0] coef;
    logic              clr;

    assign clr = reg_rd && (reg_addr == A_PK0 + ADDR_W'(c));

    vol_coef_rom #(.STEPS(STEPS), .COEF_W(COEF_W)) i_rom (
      .sel(vol_q[c]), .coef(coef));

    chan_gain #(.DATA_W(DATA_W), .COEF_W(COEF_W)) i_gain (
      .sample(in_ch[c]), .coef(coef), .mute(mute_q[c]), .result(gain_ch[c]));

    peak_hold #(.DATA_W(DATA_W)) i_peak (
      .clk(clk), .rst_n(rst_n), .in_valid(accept), .sample(in_ch[c]),
      .clr(clr), .peak(peak_ch[c]));

    zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) i_zero (
      .clk(clk), .rst_n(rst_n), .in_valid(accept), .sample(in_ch[c]),
      .flag(zflag[c]));
  end

  assign zero_l = zflag[0];
  assign zero_r = zflag[1];

  // output holding stage: gain is fixed at the accepting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_left  <= '0;
      m_right <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_left  <= gain_ch[0];
      m_right <= gain_ch[1];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // register readback
  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_VOL0:          reg_rdata <= DATA_W'(vol_q[0]);
        A_VOL0 + 1'b1:   reg_rdata <= DATA_W'(vol_q[1]);
        A_MUTE:          reg_rdata <= DATA_W'(mute_q);
        A_PK0:           reg_rdata <= peak_ch[0];
        A_PK0 + 1'b1:    reg_rdata <= peak_ch[1];
        default:         reg_rdata <= '0;
      endcase
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_left) && $stable(m_right)));
  // R3
  mute_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mute_q[0]) |=> (m_left == '0));
  // R3
  mute_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mute_q[1]) |=> (m_right == '0));
  // R4
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_valid);
endmodule

// File: tb/test_stereo_vol_peak.sv
module test_stereo_vol_peak;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int V_STEP [NV] = '{0, 1, 16, 40, 80, 160, 255, 0};
  localparam int V_LEFT [NV] = '{1000, 8388607, -8388608, 123457, -5, 4000000, 8388607, -1};
  localparam int V_RIGHT[NV] = '{-1000, -8388608, 8388607, -77, 3, -4000001, -8388608, 1};

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, m_ready = 1, reg_wr = 0, reg_rd = 0;
  logic signed [23:0] s_left = 0, s_right = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic s_ready, m_valid, zero_l, zero_r;
  logic signed [23:0] m_left, m_right;
  logic [23:0] reg_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_vol_peak i_stereo_vol_peak (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .m_valid(m_valid), .m_ready(m_ready),
    .m_left(m_left), .m_right(m_right), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .zero_l(zero_l), .zero_r(zero_r));

  function automatic longint expect_gain(longint x, int step);
    longint c;
    c = longint'($rtoi((10.0 ** (-0.375 * real'(step) / 20.0)) * 32768.0 + 0.5));
    return (x * c + 16384) >>> 15;
  endfunction

  function automatic longint mag_of(longint x);
    if (x == -8388608) return 8388607;
    return (x < 0) ? -x : x;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic read_reg(int a, output longint v);
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'(a);
    @(negedge clk);
    reg_rd = 0;
    v = longint'(reg_rdata);
  endtask

  task automatic push(longint l, longint r);
    @(negedge clk);
    s_valid = 1; s_left = 24'(l); s_right = 24'(r);
    @(negedge clk);
    s_valid = 0;
  endtask

  initial begin
    repeat (1000) @(negedge clk);
    repeat (150000) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(m_valid == 0, "R1 m_valid", m_valid, 0);
    check({zero_l, zero_r} == 0, "R1 flags", {zero_l, zero_r}, 0);
    read_reg(2, v); check(v == 3, "R1 mute", v, 3);
    read_reg(0, v); check(v == 0, "R1 vol", v, 0);
    read_reg(3, v); check(v == 0, "R1 peak", v, 0);
    // R3 muted output
    push(5000, -5000);
    check(m_left == 0 && m_right == 0, "R3 muted", m_left, 0);
    write_reg(2, 0);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      write_reg(0, V_STEP[i]);
      write_reg(1, V_STEP[i]);
      push(V_LEFT[i], V_RIGHT[i]);
      check(m_valid == 1, "R4 valid", m_valid, 1);
      check(longint'(m_left) == expect_gain(V_LEFT[i], V_STEP[i]), "R2 left",
            m_left, expect_gain(V_LEFT[i], V_STEP[i]));
      check(longint'(m_right) == expect_gain(V_RIGHT[i], V_STEP[i]), "R2 right",
            m_right, expect_gain(V_RIGHT[i], V_STEP[i]));
    end

    // R10 independent volumes and readback
    write_reg(0, 10); write_reg(1, 200);
    read_reg(1, v); check(v == 200, "R10 vol readback", v, 200);
    push(3000000, 3000000);
    check(longint'(m_left) == expect_gain(3000000, 10), "R10 left", m_left, expect_gain(3000000, 10));
    check(longint'(m_right) == expect_gain(3000000, 200), "R10 right", m_right, expect_gain(3000000, 200));

    // R3 mute only right
    write_reg(2, 2);
    push(3000000, 3000000);
    check(m_right == 0, "R3 right muted", m_right, 0);
    check(longint'(m_left) == expect_gain(3000000, 10), "R3 left live", m_left, expect_gain(3000000, 10));
    write_reg(2, 0);

    // R6/R7 peak: clear, then track max with saturating min value
    read_reg(3, v); read_reg(4, v);
    read_reg(3, v); check(v == 0, "R7 cleared", v, 0);
    push(-200, 100); push(-8388608, 50); push(700, -60);
    read_reg(3, v); check(v == mag_of(-8388608), "R6 peak sat", v, 8388607);
    read_reg(4, v); check(v == 100, "R6 peak right", v, 100);
    read_reg(3, v); check(v == 0, "R7 after read", v, 0);

    // R8 read coinciding with accepted sample
    push(900, 0);
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'd3; s_valid = 1; s_left = 24'(-321); s_right = 0;
    @(negedge clk);
    reg_rd = 0; s_valid = 0;
    check(longint'(reg_rdata) == 900, "R7 read value", reg_rdata, 900);
    read_reg(3, v); check(v == 321, "R8 coincident", v, 321);

    // R4/R5 stall: hold output, volume write applies to next sample only
    write_reg(0, 0);
    @(negedge clk);
    m_ready = 0; s_valid = 1; s_left = 24'(1000000); s_right = 0;
    @(negedge clk);
    s_left = 24'(2000000);
    check(s_ready == 0, "R4 ready low", s_ready, 0);
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'd64;
    @(negedge clk);
    reg_wr = 0;
    @(negedge clk);
    check(longint'(m_left) == 1000000, "R5 held gain", m_left, 1000000);
    check(m_valid == 1, "R4 held valid", m_valid, 1);
    m_ready = 1;
    @(negedge clk);
    s_valid = 0;
    check(longint'(m_left) == expect_gain(2000000, 64), "R5 new gain", m_left, expect_gain(2000000, 64));
    @(negedge clk);
    check(m_valid == 0, "R4 drained", m_valid, 0);

    // R9 zero run threshold on left only
    for (int k = 0; k < 1023; k++) push(0, 1);
    check(zero_l == 0, "R9 1023 zeros", zero_l, 0);
    push(0, 1);
    check(zero_l == 1, "R9 1024 zeros", zero_l, 1);
    check(zero_r == 0, "R9 right live", zero_r, 0);
    push(5, 1);
    check(zero_l == 0, "R9 drop", zero_l, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule